// File: doc/BRIEF.md
# Dual-Channel ADC Result Serializer

This block is the readout side of a two-channel converter that samples both channels at once. Each new pair of 16-bit results arrives with a one-cycle strobe and is kept in a holding register. A host reads the pair through an active-low read strobe and a serial bit clock. Both of these pins are sampled by the block's own system clock `clk`. Every pin edge therefore takes effect on the serial outputs two `clk` cycles after the edge. The host must hold each pin level for at least three `clk` cycles.

Three static inputs set how a transfer runs. The timing-mode input picks half-clock timing, where bits after the first advance on rising bit-clock edges and a read returns the previously stored result. It can instead pick full-clock timing, where bits advance on falling edges and a result whose strobe coincides with the start of the read is returned in that same read. The output-mode input picks between two lanes in parallel and one lane that carries both words. An enable attaches a 2-bit freshness tag to every word. The tag lets the host tell a new result from a stale one that it has read again.

Top module: `dual_adc_serializer`

## Requirements
- R1: While `rst` is high and after it falls, both serial outputs are 0 and the held result is zero with freshness tag 2'b01. A read straight after reset returns 16'h0000 words carrying tag 01.
- R2: While `rd_n` is high, both serial outputs are driven to 0. This also holds after `rd_n` rises in the middle of a word.
- R3: On the falling edge of `rd_n`, the most significant bit of each word is presented before any bit-clock edge.
- R4: In half-clock timing (`full_clk_mode`=0), each later bit advances on a rising `ser_clk` edge only. Falling edges leave the outputs unchanged.
- R5: In full-clock timing (`full_clk_mode`=1), each later bit advances on a falling `ser_clk` edge only. Rising edges leave the outputs unchanged.
- R6: In dual-lane operation (`single_out_mode`=0), channel A is shifted on `sdo_a` and channel B on `sdo_b` in parallel, MSB first. Once a word is complete, its lane outputs 0.
- R7: In single-lane operation (`single_out_mode`=1 with half-clock timing), `sdo_a` carries channel A MSB first and then channel B with no gap, and `sdo_b` stays 0.
- R8: Full-clock timing always uses dual-lane operation, so `single_out_mode` has no effect while `full_clk_mode`=1.
- R9: With `cnt_en`=1, the 2-bit tag follows each 16-bit word, tag MSB first. With `cnt_en`=0, no tag bits are sent.
- R10: Each strobe on `res_valid` with `cnt_en`=1 advances the tag by one modulo 4 (01, 10, 11, 00, 01, ...) and stores it with the new pair. The first result after reset therefore carries 10.
- R11: A second read with no new strobe returns the same words and the same tag.
- R12: When a strobe lands in the cycle where the falling `rd_n` edge is recognised, half-clock timing sends the previously held pair and tag. Full-clock timing sends the new pair and its advanced tag. Either way, the new pair is held for later reads.
- R13: A strobe with `cnt_en`=0 stores the new pair but leaves the tag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock from the host |
| rd_n | input | 1 | Active-low read strobe; its falling edge starts a transfer |
| res_valid | input | 1 | One-cycle strobe marking a new result pair |
| res_a | input | 16 | Channel A conversion result |
| res_b | input | 16 | Channel B conversion result |
| full_clk_mode | input | 1 | 0 = half-clock timing, 1 = full-clock timing |
| single_out_mode | input | 1 | 1 = both words on `sdo_a` (ignored in full-clock timing) |
| cnt_en | input | 1 | Enables the 2-bit freshness tag |
| sdo_a | output | 1 | Serial output lane A |
| sdo_b | output | 1 | Serial output lane B |

## Verification
The bench sweeps all eight combinations of timing mode, lane mode and tag enable, each with two data pairs whose bits differ in every nibble. It samples after every rising and after every falling bit-clock edge. The rising-edge samples separate half-clock from full-clock shifting, and the trailing bits past the word show that zeros follow it. Back-to-back reads without a strobe and strobes with the tag disabled separate a tag that tracks new results from one that tracks reads. A strobe placed in the cycle the read starts separates the stored-result path from the forwarded path.

// File: rtl/dual_ser_pkg.sv
package dual_ser_pkg;

  parameter int unsigned DATA_W_DEF = 16;
  parameter int unsigned TAG_W_DEF  = 2;
  parameter int unsigned LANES      = 2;

  typedef struct packed {
    logic full_clk;
    logic single_out;
    logic tag_en;
  } ser_mode_t;

  // one lane carries both words only in half-clock timing
  function automatic logic one_lane(input ser_mode_t m);
    return m.single_out & ~m.full_clk;
  endfunction

endpackage

// File: rtl/ser_edge_detect.sv
module ser_edge_detect #(
  parameter logic IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic s_q, s_qq;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q  <= IDLE;
      s_qq <= IDLE;
    end else begin
      s_q  <= pin_i;
      s_qq <= s_q;
    end
  end

  assign level_o = s_q;
  assign rise_o  = s_q & ~s_qq;
  assign fall_o  = ~s_q & s_qq;

endmodule

// File: rtl/ser_result_hold.sv
module ser_result_hold #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TAG_W    = 2,
  parameter logic [TAG_W-1:0] TAG_INIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_i,
  input  logic              tag_en_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] held_a_o,
  output logic [DATA_W-1:0] held_b_o,
  output logic [TAG_W-1:0]  held_tag_o,
  output logic [DATA_W-1:0] live_a_o,
  output logic [DATA_W-1:0] live_b_o,
  output logic [TAG_W-1:0]  live_tag_o
);

  logic [TAG_W-1:0] tag_next;

  assign tag_next = tag_en_i ? held_tag_o + TAG_W'(1) : held_tag_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_a_o   <= '0;
      held_b_o   <= '0;
      held_tag_o <= TAG_INIT;
    end else if (strobe_i) begin
      held_a_o   <= a_i;
      held_b_o   <= b_i;
      held_tag_o <= tag_next;
    end
  end

  // forwarding view: what the holding register will contain after this edge
  assign live_a_o   = strobe_i ? a_i      : held_a_o;
  assign live_b_o   = strobe_i ? b_i      : held_b_o;
  assign live_tag_o = strobe_i ? tag_next : held_tag_o;

endmodule

// File: rtl/ser_frame_pack.sv
module ser_frame_pack
  import dual_ser_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned TAG_W   = 2,
  localparam int unsigned WORD_W  = DATA_W + TAG_W,
  localparam int unsigned FRAME_W = 2 * WORD_W
) (
  input  ser_mode_t                     mode_i,
  input  logic [DATA_W-1:0]             a_i,
  input  logic [DATA_W-1:0]             b_i,
  input  logic [TAG_W-1:0]              tag_i,
  output logic [LANES-1:0][FRAME_W-1:0] frame_o
);

  logic [WORD_W-1:0] word_a, word_b;

  always_comb begin
    word_a = {a_i, {TAG_W{1'b0}}};
    word_b = {b_i, {TAG_W{1'b0}}};
    if (mode_i.tag_en) begin
      word_a = {a_i, tag_i};
      word_b = {b_i, tag_i};
    end
  end

  always_comb begin
    frame_o = '0;
    if (one_lane(mode_i)) begin
      if (mode_i.tag_en) frame_o[0] = {word_a, word_b};
      else               frame_o[0] = {a_i, b_i, {(2*TAG_W){1'b0}}};
    end else begin
      frame_o[0] = {word_a, {WORD_W{1'b0}}};
      frame_o[1] = {word_b, {WORD_W{1'b0}}};
    end
  end

endmodule

// File: rtl/ser_lane_shifter.sv
module ser_lane_shifter #(
  parameter int unsigned FRAME_W = 36
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               clear_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdo_o
);

  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)          sh_q <= '0;
    else if (load_i)  sh_q <= frame_i;
    else if (clear_i) sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
  end

  assign sdo_o = sh_q[FRAME_W-1];

endmodule

// File: rtl/dual_adc_serializer.sv
module dual_adc_serializer
  import dual_ser_pkg::*;
#(
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned TAG_W    = TAG_W_DEF,
  parameter logic [TAG_W-1:0] TAG_INIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              rd_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_a,
  input  logic [DATA_W-1:0] res_b,
  input  logic              full_clk_mode,
  input  logic              single_out_mode,
  input  logic              cnt_en,
  output logic              sdo_a,
  output logic              sdo_b
);

  localparam int unsigned FRAME_W = 2 * (DATA_W + TAG_W);

  ser_mode_t mode;
  assign mode.full_clk   = full_clk_mode;
  assign mode.single_out = single_out_mode;
  assign mode.tag_en     = cnt_en;

  logic rd_level, rd_rise, rd_fall;
  logic ck_level, ck_rise, ck_fall;

  ser_edge_detect #(.IDLE(1'b1)) u_rd_edge (
    .clk(clk), .rst(rst), .pin_i(rd_n),
    .level_o(rd_level), .rise_o(rd_rise), .fall_o(rd_fall)
  );

  ser_edge_detect #(.IDLE(1'b0)) u_ck_edge (
    .clk(clk), .rst(rst), .pin_i(ser_clk),
    .level_o(ck_level), .rise_o(ck_rise), .fall_o(ck_fall)
  );

  logic [DATA_W-1:0] held_a, held_b, live_a, live_b;
  logic [TAG_W-1:0]  cur_tag, live_tag;

  ser_result_hold #(.DATA_W(DATA_W), .TAG_W(TAG_W), .TAG_INIT(TAG_INIT)) u_hold (
    .clk(clk), .rst(rst), .strobe_i(res_valid), .tag_en_i(cnt_en),
    .a_i(res_a), .b_i(res_b),
    .held_a_o(held_a), .held_b_o(held_b), .held_tag_o(cur_tag),
    .live_a_o(live_a), .live_b_o(live_b), .live_tag_o(live_tag)
  );

  // half-clock reads the stored pair; full-clock may take the pair arriving now
  logic [DATA_W-1:0] src_a, src_b;
  logic [TAG_W-1:0]  src_tag;
  assign src_a   = full_clk_mode ? live_a   : held_a;
  assign src_b   = full_clk_mode ? live_b   : held_b;
  assign src_tag = full_clk_mode ? live_tag : cur_tag;

  logic [LANES-1:0][FRAME_W-1:0] frames;

  ser_frame_pack #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_pack (
    .mode_i(mode), .a_i(src_a), .b_i(src_b), .tag_i(src_tag), .frame_o(frames)
  );

  logic shift_evt;
  assign shift_evt = ~rd_level & (full_clk_mode ? ck_fall : ck_rise);

  logic [LANES-1:0] sdo;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ser_lane_shifter #(.FRAME_W(FRAME_W)) u_lane (
      .clk(clk), .rst(rst),
      .load_i(rd_fall), .clear_i(rd_level), .shift_i(shift_evt),
      .frame_i(frames[g]), .sdo_o(sdo[g])
    );
  end

  assign sdo_a = sdo[0];
  assign sdo_b = sdo[1];

endmodule

// File: rtl/dual_adc_serializer_chk.sv
module dual_adc_serializer_chk #(
  parameter int unsigned TAG_W = 2,
  parameter logic [TAG_W-1:0] TAG_INIT = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_n,
  input logic             res_valid,
  input logic             cnt_en,
  input logic             full_clk_mode,
  input logic             single_out_mode,
  input logic             sdo_a,
  input logic             sdo_b,
  input logic             rd_rise,
  input logic             rd_fall,
  input logic             ck_rise,
  input logic             ck_fall,
  input logic [TAG_W-1:0] cur_tag
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_tag == TAG_INIT) && !sdo_a && !sdo_b);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_n, 2) && $past(rd_n) |-> !sdo_a && !sdo_b);

  // R4
  half_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !full_clk_mode && $past(!full_clk_mode) && $past(ck_fall) &&
    !$past(rd_fall) && !$past(rd_rise) |-> $stable(sdo_a) && $stable(sdo_b));

  // R5
  full_edge_chk: assert property (@(posedge clk) disable iff (rst)
    full_clk_mode && $past(full_clk_mode) && $past(ck_rise) &&
    !$past(rd_fall) && !$past(rd_rise) |-> $stable(sdo_a) && $stable(sdo_b));

  // R6
  no_event_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_fall) && !$past(rd_rise) && !$past(ck_rise) && !$past(ck_fall)
    |-> $stable(sdo_a) && $stable(sdo_b));

  // R7
  one_lane_b_chk: assert property (@(posedge clk) disable iff (rst)
    single_out_mode && !full_clk_mode &&
    $past(single_out_mode && !full_clk_mode) &&
    $past(single_out_mode && !full_clk_mode, 2) |-> !sdo_b);

  // R10
  tag_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(res_valid) && $past(cnt_en) |-> cur_tag == $past(cur_tag) + TAG_W'(1));

  // R13
  tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !($past(res_valid) && $past(cnt_en)) |-> $stable(cur_tag));

endmodule

bind dual_adc_serializer dual_adc_serializer_chk #(.TAG_W(TAG_W), .TAG_INIT(TAG_INIT)) u_chk (
  .clk(clk), .rst(rst), .rd_n(rd_n), .res_valid(res_valid), .cnt_en(cnt_en),
  .full_clk_mode(full_clk_mode), .single_out_mode(single_out_mode),
  .sdo_a(sdo_a), .sdo_b(sdo_b),
  .rd_rise(rd_rise), .rd_fall(rd_fall), .ck_rise(ck_rise), .ck_fall(ck_fall),
  .cur_tag(cur_tag)
);

// File: tb/dual_adc_serializer_bench.sv
module dual_adc_serializer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 40;   // bits observed per read: 36 frame bits plus trailing zeros
  localparam int GAP = 4;   // clk cycles between pin changes

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic rd_n = 1'b1;
  logic res_valid = 1'b0;
  logic [15:0] res_a = '0, res_b = '0;
  logic full_clk_mode = 1'b0, single_out_mode = 1'b0, cnt_en = 1'b0;
  logic sdo_a, sdo_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_adc_serializer u_dual_adc_serializer (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .rd_n(rd_n),
    .res_valid(res_valid), .res_a(res_a), .res_b(res_b),
    .full_clk_mode(full_clk_mode), .single_out_mode(single_out_mode),
    .cnt_en(cnt_en), .sdo_a(sdo_a), .sdo_b(sdo_b)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model of the held pair and tag
  logic [15:0] m_a = '0, m_b = '0;
  logic [1:0]  m_tag = 2'b01;

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    res_a = a; res_b = b; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    m_a = a; m_b = b;
    if (cnt_en) m_tag = m_tag + 2'd1;
  endtask

  // expected bit sequence per lane, index 0 = first bit on the wire
  task automatic build(input logic [15:0] a, input logic [15:0] b, input logic [1:0] t,
                       output logic [NB-1:0] ea, output logic [NB-1:0] eb);
    int pa, pb;
    bit one;
    one = single_out_mode && !full_clk_mode;
    ea = '0; eb = '0; pa = 0; pb = 0;
    for (int i = 15; i >= 0; i--) begin ea[pa] = a[i]; pa++; end
    if (cnt_en) begin ea[pa] = t[1]; ea[pa+1] = t[0]; pa += 2; end
    if (one) begin
      for (int i = 15; i >= 0; i--) begin ea[pa] = b[i]; pa++; end
      if (cnt_en) begin ea[pa] = t[1]; ea[pa+1] = t[0]; end
    end else begin
      for (int i = 15; i >= 0; i--) begin eb[pb] = b[i]; pb++; end
      if (cnt_en) begin eb[pb] = t[1]; eb[pb+1] = t[0]; end
    end
  endtask

  task automatic do_read(input string req, input bit coinc,
                         input logic [15:0] na, input logic [15:0] nb);
    logic [NB-1:0] ea, eb, era, erb, ga_r, ga_f, gb_r, gb_f;
    logic [15:0] xa, xb;
    logic [1:0] xt;
    if (coinc && full_clk_mode) begin
      xa = na; xb = nb; xt = cnt_en ? m_tag + 2'd1 : m_tag;
    end else begin
      xa = m_a; xb = m_b; xt = m_tag;
    end
    build(xa, xb, xt, ea, eb);
    if (full_clk_mode) begin
      era = ea << 1; era[0] = ea[0];
      erb = eb << 1; erb[0] = eb[0];
    end else begin
      era = ea; erb = eb;
    end
    ga_r = '0; ga_f = '0; gb_r = '0; gb_f = '0;
    @(negedge clk);
    rd_n = 1'b0;
    if (coinc) begin
      @(negedge clk);
      res_a = na; res_b = nb; res_valid = 1'b1;
      @(negedge clk);
      res_valid = 1'b0;
      m_a = na; m_b = nb;
      if (cnt_en) m_tag = m_tag + 2'd1;
      wait_n(GAP - 2);
    end else begin
      wait_n(GAP);
    end
    ga_r[0] = sdo_a; ga_f[0] = sdo_a; gb_r[0] = sdo_b; gb_f[0] = sdo_b;
    check({req, " R3 first bit"}, {sdo_a, sdo_b}, {ea[0], eb[0]});
    for (int i = 1; i < NB; i++) begin
      ser_clk = 1'b1; wait_n(GAP);
      ga_r[i] = sdo_a; gb_r[i] = sdo_b;
      ser_clk = 1'b0; wait_n(GAP);
      ga_f[i] = sdo_a; gb_f[i] = sdo_b;
    end
    check({req, " lane A"}, {ga_r, ga_f}, {era, ea});
    check({req, " lane B"}, {gb_r, gb_f}, {erb, eb});
    rd_n = 1'b1;
    wait_n(GAP);
    check({req, " R2 idle after read"}, {sdo_a, sdo_b}, 2'b00);
  endtask

  task automatic set_mode(input bit f, input bit s, input bit e);
    @(negedge clk);
    full_clk_mode = f; single_out_mode = s; cnt_en = e;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    string lbl;
    wait_n(4);
    check("R1 outputs during reset", {sdo_a, sdo_b}, 2'b00);
    rst = 1'b0;
    wait_n(GAP);
    check("R1 outputs after reset", {sdo_a, sdo_b}, 2'b00);

    // R1 / R10: first read after reset shows zero data with tag 01
    set_mode(1'b0, 1'b0, 1'b1);
    do_read("R1 R10 reset tag", 1'b0, '0, '0);

    // R2: rd_n rises in mid word, outputs return to zero
    load(16'hFFFF, 16'hFFFF);
    @(negedge clk); rd_n = 1'b0; wait_n(GAP);
    ser_clk = 1'b1; wait_n(GAP); ser_clk = 1'b0; wait_n(GAP);
    check("R2 mid word data", {sdo_a, sdo_b}, 2'b11);
    rd_n = 1'b1; wait_n(GAP);
    check("R2 mid word abort", {sdo_a, sdo_b}, 2'b00);

    // sweep of timing mode, lane mode, tag enable and data
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < 2; s++) begin
        for (int e = 0; e < 2; e++) begin
          for (int p = 0; p < 2; p++) begin
            logic [15:0] a, b;
            a = 16'hA5C3 ^ 16'(p * 16'h5A5A + f * 16'h0F0F + s * 16'h3333 + e * 16'h1111);
            b = ~a ^ 16'(16'h6E29 + p * 16'h0101);
            set_mode(f[0], s[0], e[0]);
            load(a, b);
            lbl = $sformatf("%s %s %s", f ? "R5" : "R4",
                            (s && !f) ? "R7" : (s ? "R8" : "R6"),
                            e ? "R9 R10" : "R9 off");
            do_read(lbl, 1'b0, '0, '0);
          end
        end
      end
    end

    // R11: repeated reads without a new result
    set_mode(1'b0, 1'b0, 1'b1);
    load(16'h1357, 16'h9BDF);
    do_read("R11 first read", 1'b0, '0, '0);
    do_read("R11 repeat read", 1'b0, '0, '0);
    set_mode(1'b1, 1'b0, 1'b1);
    do_read("R11 repeat read full", 1'b0, '0, '0);

    // R13: strobes with the tag disabled leave it unchanged
    set_mode(1'b0, 1'b0, 1'b0);
    load(16'h0F1E, 16'h2D3C);
    load(16'h4B5A, 16'h6978);
    set_mode(1'b0, 1'b0, 1'b1);
    do_read("R13 tag held while disabled", 1'b0, '0, '0);
    load(16'h8796, 16'hA5B4);
    do_read("R13 R10 tag resumes", 1'b0, '0, '0);

    // R10: wrap through all four tag values
    for (int k = 0; k < 5; k++) begin
      load(16'(16'h1000 * k + 16'h0123), 16'(16'hF000 - 16'h0111 * k));
      do_read("R10 tag wrap", 1'b0, '0, '0);
    end

    // R12: strobe coincident with the start of a read
    set_mode(1'b0, 1'b0, 1'b1);
    load(16'hC0DE, 16'hBEEF);
    do_read("R12 half keeps old pair", 1'b1, 16'h1234, 16'h5678);
    do_read("R12 half new pair next read", 1'b0, '0, '0);
    set_mode(1'b1, 1'b0, 1'b1);
    do_read("R12 full forwards new pair", 1'b1, 16'h9ABC, 16'hDEF0);
    do_read("R12 full same pair again", 1'b0, '0, '0);

    summary();
  end

endmodule